// File: doc/BRIEF.md
# Auto-Increment Flash Program Sequencer

This block is the host-side engine that writes a run of bytes into a serial NOR flash using the device's word-pair auto-address-increment programming mode. Software or a parent block supplies a 24-bit start address, a byte count and a one-cycle start strobe. The block then pulls data bytes one at a time through a request/valid handshake and drives a byte-level SPI shifter. For each byte it raises a go strobe with the byte to send and waits for the shifter's done strobe, while holding chip select around each command.

The transfer is split into three parts. An odd start address first gets a one-byte program. The aligned middle is streamed as two-byte frames, and only the first of these carries the address. A single byte left over at the end gets its own one-byte program. After every program frame the block reads the status register until the write-in-progress bit clears. If that bit stays set for a programmable number of reads, the block gives up and flags an error.

Top module: `aai_prog_seq`

## Requirements
- R1: A start with length 0 raises `done` in the next cycle with `err` low, and it asserts no chip select and requests no data.
- R2: A single-byte program is two chip-select frames: write-enable `0x06` alone, then `0x02`, the three address bytes (bits 23:16, then 15:8, then 7:0) and one data byte.
- R3: When the start address is odd (bit 0 = 1) and the length is non-zero, the first byte is written by a single-byte program at the start address.
- R4: The even-aligned part of at least two bytes is sent as follows. First comes write-enable `0x06`. Next comes a frame of `0xAD`, the three address bytes MSB first and two data bytes. Each later pair is sent in a frame of `0xAD` and two data bytes only, with no address.
- R5: After the status poll of the last pair frame, a write-disable frame holding only `0x04` is sent before any further command.
- R6: One byte left after the pairs is written by a single-byte program at the address just past the last pair.
- R7: Every frame that starts with `0x02` or `0xAD` is followed by status poll frames. Each poll frame sends `0x05` and then a dummy `0x00`, and bit 0 of the byte received during the dummy is the busy flag. Polling repeats while that bit is 1, and no other command is issued until it reads 0.
- R8: Each command and each poll occupies its own chip-select frame, and chip select is low for at least one cycle between frames. A go strobe happens only inside a frame, and at most one byte is outstanding at the shifter.
- R9: If `poll_limit` (non-zero) consecutive polls after one program frame all read busy, the sequence stops after that poll. `done` is raised together with `err`, and `err` stays high until the next start.
- R10: Length 1 at an even address produces exactly one single-byte program with its poll(s), and no `0xAD` or `0x04` frame.
- R11: Data bytes are consumed in order, one in each cycle where `data_req` and `data_valid` are both high. `data_req` is high only inside a frame, and exactly `length` bytes are consumed in a run that is not aborted.
- R12: After reset the block is idle with all outputs low. `busy` is high from the cycle after start until the cycle `done` is high. `done` lasts one cycle, and a new start clears `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transfer (taken when idle) |
| start_addr | input | 24 | First flash byte address |
| length | input | LEN_W | Number of bytes to write |
| poll_limit | input | POLL_W | Busy polls allowed per program frame before abort |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Busy-poll timeout; valid with `done`, held until next start |
| data_req | output | 1 | Request for the next data byte |
| data_valid | input | 1 | Data byte offered; consumed when `data_req` is high |
| data_byte | input | 8 | Data byte |
| spi_cs | output | 1 | Chip select asserted (active high at this interface) |
| spi_go | output | 1 | Start shifting `spi_tx` |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | Shifter finished the current byte |
| spi_rx | input | 8 | Byte received during the finished transfer |

## Verification
The bench builds the block with `LEN_W` = 16 and `POLL_W` = 8. An 8-bit poll limit lets the timeout case be reached after three busy reads, while the model can hold the busy flag for dozens of reads. The flash model sets its busy count per run, from zero up to forty reads. This covers polling that clears at once, polling that takes several reads, and a stall that exceeds the limit. Start addresses include a run across a 64 KiB boundary, so the address carried in the first pair frame differs from the start address in its upper byte. A throttled data source drives the request/valid handshake at half rate.

// File: rtl/aai_pkg.sv
package aai_pkg;
  localparam logic [7:0] OP_WR_EN   = 8'h06;
  localparam logic [7:0] OP_WR_DIS  = 8'h04;
  localparam logic [7:0] OP_STATUS  = 8'h05;
  localparam logic [7:0] OP_BYTE    = 8'h02;
  localparam logic [7:0] OP_PAIR    = 8'hAD;
  localparam int         ADDR_BYTES = 3;
  localparam int         ADDR_W     = 8 * ADDR_BYTES;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_NEXT, SQ_WREN, SQ_PROG, SQ_POLL, SQ_WRDI, SQ_FIN
  } seq_st_t;

  typedef enum logic [2:0] {
    FX_IDLE, FX_SEL, FX_WAIT, FX_DREQ
  } frm_st_t;
endpackage

// File: rtl/aai_split.sv
module aai_split #(
  parameter int LEN_W = 16
) (
  input  logic             addr_lsb,
  input  logic [LEN_W-1:0] length,
  output logic             head,
  output logic [LEN_W-1:0] pairs,
  output logic             tail
);
  logic [LEN_W-1:0] rest;

  always_comb begin
    head  = addr_lsb && (length != '0);
    rest  = length - {{(LEN_W-1){1'b0}}, head};
    pairs = rest >> 1;
    tail  = rest[0];
  end
endmodule

// File: rtl/aai_busy_watch.sv
module aai_busy_watch #(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              busy_seen,
  input  logic [POLL_W-1:0] limit,
  output logic              expire
);
  logic [POLL_W-1:0] cnt;

  assign expire = busy_seen && (cnt == limit - POLL_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (busy_seen) cnt <= cnt + POLL_W'(1);
  end
endmodule

// File: rtl/aai_frame_tx.sv
module aai_frame_tx
  import aai_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              f_start,
  input  logic [7:0]        f_op,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic              f_use_addr,
  input  logic [1:0]        f_ndata,
  input  logic              f_read,
  output logic              f_done,
  output logic [7:0]        f_rx,
  output logic              spi_cs,
  output logic              spi_go,
  output logic [7:0]        spi_tx,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx,
  output logic              data_req,
  input  logic              data_valid,
  input  logic [7:0]        data_byte
);
  localparam int AL_W = $clog2(ADDR_BYTES + 1);

  frm_st_t           st;
  logic [ADDR_W-1:0] addr_q;
  logic [AL_W-1:0]   a_left;
  logic [1:0]        d_left;
  logic              rd_pend, rd_act;
  logic              cs_r, go_r, req_r, done_r;
  logic [7:0]        tx_r, rx_q;

  assign spi_cs   = cs_r;
  assign spi_go   = go_r;
  assign spi_tx   = tx_r;
  assign data_req = req_r;
  assign f_done   = done_r;
  assign f_rx     = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FX_IDLE;
      addr_q  <= '0;
      a_left  <= '0;
      d_left  <= '0;
      rd_pend <= 1'b0;
      rd_act  <= 1'b0;
      cs_r    <= 1'b0;
      go_r    <= 1'b0;
      req_r   <= 1'b0;
      done_r  <= 1'b0;
      tx_r    <= '0;
      rx_q    <= '0;
    end else begin
      go_r   <= 1'b0;
      done_r <= 1'b0;
      case (st)
        FX_IDLE: begin
          if (f_start) begin
            addr_q  <= f_addr;
            a_left  <= f_use_addr ? AL_W'(ADDR_BYTES) : '0;
            d_left  <= f_ndata;
            rd_pend <= f_read;
            cs_r    <= 1'b1;
            tx_r    <= f_op;
            go_r    <= 1'b1;
            st      <= FX_WAIT;
          end
        end
        FX_SEL: begin
          if (a_left != '0) begin
            tx_r   <= addr_q[ADDR_W-1 -: 8];
            addr_q <= addr_q << 8;
            a_left <= a_left - AL_W'(1);
            go_r   <= 1'b1;
            st     <= FX_WAIT;
          end else if (d_left != 2'd0) begin
            req_r <= 1'b1;
            st    <= FX_DREQ;
          end else if (rd_pend) begin
            rd_pend <= 1'b0;
            rd_act  <= 1'b1;
            tx_r    <= 8'h00;
            go_r    <= 1'b1;
            st      <= FX_WAIT;
          end else begin
            cs_r   <= 1'b0;
            done_r <= 1'b1;
            st     <= FX_IDLE;
          end
        end
        FX_WAIT: begin
          if (spi_done) begin
            if (rd_act) begin
              rx_q   <= spi_rx;
              rd_act <= 1'b0;
            end
            st <= FX_SEL;
          end
        end
        FX_DREQ: begin
          if (data_valid) begin
            req_r  <= 1'b0;
            tx_r   <= data_byte;
            go_r   <= 1'b1;
            d_left <= d_left - 2'd1;
            st     <= FX_WAIT;
          end
        end
        default: st <= FX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aai_prog_seq.sv
module aai_prog_seq
  import aai_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [23:0]       start_addr,
  input  logic [LEN_W-1:0]  length,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              data_req,
  input  logic              data_valid,
  input  logic [7:0]        data_byte,
  output logic              spi_cs,
  output logic              spi_go,
  output logic [7:0]        spi_tx,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx
);
  seq_st_t           st;
  logic [ADDR_W-1:0] cur_addr;
  logic              head_q, tail_q, pair_mode, first_q, launched, err_r;
  logic [LEN_W-1:0]  pairs_q;

  logic              sp_head, sp_tail;
  logic [LEN_W-1:0]  sp_pairs;

  logic              f_start, f_done, f_use_addr, f_read;
  logic [7:0]        f_op, f_rx;
  logic [1:0]        f_ndata;
  logic              poll_end, rd_busy, expire;

  aai_split #(.LEN_W(LEN_W)) u_split (
    .addr_lsb (start_addr[0]),
    .length   (length),
    .head     (sp_head),
    .pairs    (sp_pairs),
    .tail     (sp_tail)
  );

  assign poll_end = (st == SQ_POLL) && f_done;
  assign rd_busy  = f_rx[0];

  aai_busy_watch #(.POLL_W(POLL_W)) u_watch (
    .clk       (clk),
    .rst       (rst),
    .clr       ((st == SQ_IDLE) || (poll_end && !rd_busy)),
    .busy_seen (poll_end && rd_busy),
    .limit     (poll_limit),
    .expire    (expire)
  );

  always_comb begin
    f_op       = OP_WR_EN;
    f_use_addr = 1'b0;
    f_ndata    = 2'd0;
    f_read     = 1'b0;
    case (st)
      SQ_PROG: begin
        f_op       = pair_mode ? OP_PAIR : OP_BYTE;
        f_use_addr = pair_mode ? first_q : 1'b1;
        f_ndata    = pair_mode ? 2'd2 : 2'd1;
      end
      SQ_POLL: begin
        f_op   = OP_STATUS;
        f_read = 1'b1;
      end
      SQ_WRDI: f_op = OP_WR_DIS;
      default: ;
    endcase
    f_start = !launched &&
              (st == SQ_WREN || st == SQ_PROG || st == SQ_POLL || st == SQ_WRDI);
  end

  aai_frame_tx u_frame (
    .clk        (clk),
    .rst        (rst),
    .f_start    (f_start),
    .f_op       (f_op),
    .f_addr     (cur_addr),
    .f_use_addr (f_use_addr),
    .f_ndata    (f_ndata),
    .f_read     (f_read),
    .f_done     (f_done),
    .f_rx       (f_rx),
    .spi_cs     (spi_cs),
    .spi_go     (spi_go),
    .spi_tx     (spi_tx),
    .spi_done   (spi_done),
    .spi_rx     (spi_rx),
    .data_req   (data_req),
    .data_valid (data_valid),
    .data_byte  (data_byte)
  );

  assign busy = (st != SQ_IDLE);
  assign done = (st == SQ_FIN);
  assign err  = err_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      cur_addr  <= '0;
      head_q    <= 1'b0;
      tail_q    <= 1'b0;
      pairs_q   <= '0;
      pair_mode <= 1'b0;
      first_q   <= 1'b0;
      launched  <= 1'b0;
      err_r     <= 1'b0;
    end else begin
      if (f_start) launched <= 1'b1;
      else if (f_done) launched <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            err_r    <= 1'b0;
            cur_addr <= start_addr;
            head_q   <= sp_head;
            pairs_q  <= sp_pairs;
            tail_q   <= sp_tail;
            st       <= (length == '0) ? SQ_FIN : SQ_NEXT;
          end
        end
        SQ_NEXT: begin
          if (head_q) begin
            pair_mode <= 1'b0;
            st        <= SQ_WREN;
          end else if (pairs_q != '0) begin
            pair_mode <= 1'b1;
            first_q   <= 1'b1;
            st        <= SQ_WREN;
          end else if (tail_q) begin
            pair_mode <= 1'b0;
            st        <= SQ_WREN;
          end else begin
            st <= SQ_FIN;
          end
        end
        SQ_WREN: if (f_done) st <= SQ_PROG;
        SQ_PROG: if (f_done) st <= SQ_POLL;
        SQ_POLL: begin
          if (f_done) begin
            if (rd_busy) begin
              if (expire) begin
                err_r <= 1'b1;
                st    <= SQ_FIN;
              end
            end else if (!pair_mode) begin
              if (head_q) head_q <= 1'b0;
              else tail_q <= 1'b0;
              cur_addr <= cur_addr + ADDR_W'(1);
              st       <= SQ_NEXT;
            end else begin
              pairs_q  <= pairs_q - LEN_W'(1);
              cur_addr <= cur_addr + ADDR_W'(2);
              first_q  <= 1'b0;
              st       <= (pairs_q == LEN_W'(1)) ? SQ_WRDI : SQ_PROG;
            end
          end
        end
        SQ_WRDI: if (f_done) st <= SQ_NEXT;
        SQ_FIN:  st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aai_prog_seq_chk.sv
module aai_prog_seq_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [LEN_W-1:0] length,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             data_req,
  input logic             spi_cs,
  input logic             spi_go,
  input logic             spi_done
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else if (spi_go) pend <= 1'b1;
    else if (spi_done) pend <= 1'b0;
  end

  p_go_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
    spi_go |-> spi_cs);

  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (rst)
    spi_go |-> !pend);

  p_cs_gap_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs) |=> !spi_cs);

  p_req_in_frame_r11: assert property (@(posedge clk) disable iff (rst)
    data_req |-> spi_cs);

  p_zero_len_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && length == '0) |=> (done && !err && !spi_cs));

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!spi_cs && !data_req));
endmodule

bind aai_prog_seq aai_prog_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .length   (length),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .data_req (data_req),
  .spi_cs   (spi_cs),
  .spi_go   (spi_go),
  .spi_done (spi_done)
);

// File: tb/aai_prog_seq_bench.sv
module aai_prog_seq_bench;
  localparam int LEN_W  = 16;
  localparam int POLL_W = 8;
  localparam int MAXF   = 512;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [23:0]       start_addr = '0;
  logic [LEN_W-1:0]  length = '0;
  logic [POLL_W-1:0] poll_limit = 8'd20;
  logic              busy, done, err, data_req, data_valid;
  logic [7:0]        data_byte;
  logic              spi_cs, spi_go;
  logic [7:0]        spi_tx;
  logic              spi_done = 1'b0;
  logic [7:0]        spi_rx = 8'h00;

  int n_chk = 0;
  int n_bad = 0;

  aai_prog_seq #(.LEN_W(LEN_W), .POLL_W(POLL_W)) u_aai_prog_seq (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .length(length), .poll_limit(poll_limit), .busy(busy), .done(done),
    .err(err), .data_req(data_req), .data_valid(data_valid),
    .data_byte(data_byte), .spi_cs(spi_cs), .spi_go(spi_go),
    .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx)
  );

  // data source
  localparam logic [7:0] DSEED = 8'h3C;
  logic dv_slow = 1'b0;
  logic tog = 1'b0;
  int   didx = 0;
  assign data_valid = data_req && (!dv_slow || tog);
  assign data_byte  = DSEED + 8'(didx * 5);
  always @(posedge clk) begin
    tog <= ~tog;
    if (data_req && data_valid) didx <= didx + 1;
  end

  // SPI shifter and flash model
  logic [7:0] fb [0:MAXF-1][0:5];
  int fn [0:MAXF-1];
  int nfr = 0;
  int pos = 0;
  int busy_left = 0;
  int busy_per_op = 0;
  int sp_cnt = 0;
  logic cs_q = 1'b0;

  always @(posedge clk) begin : model
    int fi;
    if (rst) begin
      cs_q     <= 1'b0;
      sp_cnt   <= 0;
      spi_done <= 1'b0;
    end else begin
      cs_q     <= spi_cs;
      spi_done <= 1'b0;
      if (start) busy_left = 0;
      if (spi_cs && !cs_q) begin
        fi  = nfr;
        nfr = nfr + 1;
        pos = 0;
        if (fi < MAXF) fn[fi] = 0;
      end else begin
        fi = nfr - 1;
      end
      if (spi_go) begin
        if (fi >= 0 && fi < MAXF && pos < 6) begin
          fb[fi][pos] = spi_tx;
          fn[fi] = pos + 1;
        end
        if (pos == 1 && fi >= 0 && fi < MAXF && fb[fi][0] == 8'h05) begin
          spi_rx <= {7'd0, (busy_left > 0)};
          if (busy_left > 0) busy_left = busy_left - 1;
        end else begin
          spi_rx <= 8'h00;
        end
        pos = pos + 1;
        sp_cnt <= 2;
      end else if (sp_cnt > 0) begin
        sp_cnt <= sp_cnt - 1;
        if (sp_cnt == 1) spi_done <= 1'b1;
      end
      if (!spi_cs && cs_q && fi >= 0 && fi < MAXF &&
          (fb[fi][0] == 8'h02 || fb[fi][0] == 8'hAD))
        busy_left = busy_per_op;
    end
  end

  // expected frames
  logic [7:0] ex_b [0:63][0:5];
  int ex_n [0:63];
  int ne = 0;

  task automatic add_fr(input int n, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [7:0] b3,
                        input logic [7:0] b4, input logic [7:0] b5);
    if (ne < 64) begin
      ex_b[ne][0] = b0; ex_b[ne][1] = b1; ex_b[ne][2] = b2;
      ex_b[ne][3] = b3; ex_b[ne][4] = b4; ex_b[ne][5] = b5;
      ex_n[ne] = n;
    end
    ne++;
  endtask

  function automatic logic [7:0] dval(input int i);
    return DSEED + 8'(i * 5);
  endfunction

  function automatic logic [55:0] act_pack(input int fi);
    logic [55:0] v;
    v = {8'(fn[fi]), 48'd0};
    for (int k = 0; k < 6; k++)
      if (k < fn[fi]) v[47-8*k -: 8] = fb[fi][k];
    return v;
  endfunction

  function automatic logic [55:0] exp_pack(input int ei);
    logic [55:0] v;
    v = {8'(ex_n[ei]), 48'd0};
    for (int k = 0; k < 6; k++)
      if (k < ex_n[ei]) v[47-8*k -: 8] = ex_b[ei][k];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic polls(input int bpo, input int lim, inout bit ab);
    if (bpo >= lim) begin
      for (int k = 0; k < lim; k++) add_fr(2, 8'h05, 8'h00, 0, 0, 0, 0);
      ab = 1'b1;
    end else begin
      for (int k = 0; k <= bpo; k++) add_fr(2, 8'h05, 8'h00, 0, 0, 0, 0);
    end
  endtask

  task automatic run_seq(input string tag, input logic [23:0] a, input int len,
                         input int bpo, input int lim, input bit slow,
                         output int cyc);
    int nf0, d0, dc, rem, nact;
    logic [23:0] ca;
    bit ab, first;
    @(negedge clk);
    busy_per_op = bpo;
    dv_slow     = slow;
    poll_limit  = POLL_W'(lim);
    nf0 = nfr;
    d0  = didx;
    start_addr = a;
    length     = LEN_W'(len);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R12", "busy after start", busy, 1);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, tag, "done reached", done, 1);
    // expected sequence
    ne = 0; ab = 1'b0; dc = 0; ca = a; rem = len;
    if (len > 0 && a[0]) begin
      add_fr(1, 8'h06, 0, 0, 0, 0, 0);
      add_fr(5, 8'h02, ca[23:16], ca[15:8], ca[7:0], dval(d0 + dc), 0);
      dc++;
      polls(bpo, lim, ab);
      ca = ca + 24'd1;
      rem--;
    end
    if (!ab && rem >= 2) begin
      add_fr(1, 8'h06, 0, 0, 0, 0, 0);
      first = 1'b1;
      while (rem >= 2 && !ab) begin
        if (first)
          add_fr(6, 8'hAD, ca[23:16], ca[15:8], ca[7:0], dval(d0 + dc), dval(d0 + dc + 1));
        else
          add_fr(3, 8'hAD, dval(d0 + dc), dval(d0 + dc + 1), 0, 0, 0);
        dc += 2;
        polls(bpo, lim, ab);
        first = 1'b0;
        ca = ca + 24'd2;
        rem -= 2;
      end
      if (!ab) add_fr(1, 8'h04, 0, 0, 0, 0, 0);
    end
    if (!ab && rem == 1) begin
      add_fr(1, 8'h06, 0, 0, 0, 0, 0);
      add_fr(5, 8'h02, ca[23:16], ca[15:8], ca[7:0], dval(d0 + dc), 0);
      dc++;
      polls(bpo, lim, ab);
    end
    chk(err == ab, ab ? "R9" : tag, "err flag", err, ab);
    nact = nfr - nf0;
    chk(nact == ne, "R8", {tag, " frame count"}, nact, ne);
    for (int i = 0; i < ne && i < nact && i < 64; i++)
      chk(act_pack(nf0 + i) == exp_pack(i), "R2", {tag, " frame bytes"},
          act_pack(nf0 + i), exp_pack(i));
    chk((didx - d0) == dc, "R11", {tag, " bytes consumed"}, didx - d0, dc);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R12", "done is one cycle", {done, busy}, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk({busy, done, err, spi_cs, spi_go, data_req} == 6'b0, "R12",
        "outputs in reset", {busy, done, err, spi_cs, spi_go, data_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, err, spi_cs} == 4'b0, "R12", "idle after reset",
        {busy, done, err, spi_cs}, 0);
  endtask

  task automatic t_zero;
    int c;
    run_seq("R1", 24'h001234, 0, 0, 20, 1'b0, c);
    chk(c == 0, "R1", "zero length completes next cycle", c, 0);
  endtask

  task automatic t_even_one;
    int c;
    run_seq("R10", 24'h012346, 1, 1, 20, 1'b0, c);
  endtask

  task automatic t_odd_one;
    int c;
    run_seq("R3", 24'h000011, 1, 0, 20, 1'b0, c);
  endtask

  task automatic t_even_pairs;
    int c;
    run_seq("R4", 24'h200000, 6, 1, 20, 1'b0, c);
  endtask

  task automatic t_odd_span;
    int c;
    run_seq("R6", 24'h00FFFF, 6, 1, 20, 1'b0, c);
  endtask

  task automatic t_even_tail;
    int c;
    run_seq("R5", 24'h0000F0, 3, 0, 20, 1'b0, c);
  endtask

  task automatic t_slow_busy;
    int c;
    run_seq("R7", 24'h0A0010, 4, 3, 20, 1'b1, c);
  endtask

  task automatic t_timeout;
    int c;
    run_seq("R9", 24'h000200, 2, 40, 3, 1'b0, c);
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R9", "err held after abort", err, 1);
    chk(spi_cs == 1'b0, "R9", "no frame after abort", spi_cs, 0);
  endtask

  task automatic t_err_clear;
    int c;
    run_seq("R12", 24'h000101, 3, 0, 20, 1'b0, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_even_one();
    t_odd_one();
    t_even_pairs();
    t_odd_span();
    t_even_tail();
    t_slow_busy();
    t_timeout();
    t_err_clear();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule